// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block chooses which of eight interrupt request lines is served next, and which in-service line a general end-of-interrupt command releases. Priority is a ring: a stored lowest-priority pointer names the pin that ranks last, and the pin just above it ranks first. The rest follow in order, wrapping around after pin 7. The request, in-service and mask vectors come from registers outside the block and feed in as inputs. Two mode flags change how in-service bits block requests. One makes in-service bits irrelevant to request selection. The other exempts the cascade input, pin 2, from that blocking.

Both selections are purely combinational. The only state is the lowest-priority pointer. It is updated by a one-cycle command on `op`: initialisation, a general end-of-interrupt, an end-of-interrupt for a named pin, a direct priority set, or an auto-EOI acknowledge. The surrounding controller decodes its register writes into these commands. It also uses the two selected pins to latch in-service bits and to form interrupt vectors.

Top module: `irq_prio_resolver`

## Requirements
- R1: With pointer value L, the scan visits pins L+1, L+2, ... modulo 8, eight pins in all. `req_pin` and `svc_pin` are binary pin numbers 0..7.
- R2: A pin can win the request selection only when its `req_bits` bit is 1 and its `mask_bits` bit is 0. `req_hit` is 1 exactly when such a pin is chosen.
- R3: With both mode flags low, the scan stops at the first pin in scan order whose `svc_bits` bit is 1. That pin and every later pin cannot win, so `req_hit` is 0 unless an eligible pin comes strictly earlier.
- R4: With `smm_en` high, `svc_bits` has no effect on the request selection.
- R5: With `sfn_en` high and `smm_en` low, bit 2 of `svc_bits` does not block. All other in-service bits still block as in R3.
- R6: `svc_pin` is the first pin in scan order whose `svc_bits` bit is 1. `svc_hit` is 0 when no such pin exists.
- R7: With `smm_en` high, in-service pins whose mask bit is 1 are skipped by the in-service selection.
- R8: After reset, and one cycle after an `op` of 1 (initialise), the pointer `low_pin` is 7, so pin 0 ranks first.
- R9: An `op` of 2 (general end-of-interrupt) with `rotate_en` high and `svc_hit` high loads the pointer with `svc_pin` at the next edge. Without `rotate_en`, or with no in-service pin, the pointer is unchanged.
- R10: An `op` of 3 (pin end-of-interrupt) with `rotate_en` high loads the pointer with `op_pin`. With `rotate_en` low the pointer is unchanged.
- R11: An `op` of 4 (priority set) with `rotate_en` high loads the pointer with `op_pin`. With `rotate_en` low it has no effect on the pointer.
- R12: An `op` of 5 (auto-EOI acknowledge of pin `op_pin`) with `rotate_en` high loads the pointer with `op_pin`.
- R13: An `op` of 0, 6 or 7 leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_bits | input | 8 | Latched request bits |
| svc_bits | input | 8 | In-service bits |
| mask_bits | input | 8 | Mask bits, 1 = masked |
| smm_en | input | 1 | Special mask mode flag |
| sfn_en | input | 1 | Special fully-nested mode flag |
| op | input | 3 | Pointer command code (0 none, 1 init, 2 general EOI, 3 pin EOI, 4 priority set, 5 auto-EOI acknowledge) |
| op_pin | input | 3 | Pin named by the command |
| rotate_en | input | 1 | Rotation enabled for this command |
| req_hit | output | 1 | A request was selected |
| req_pin | output | 3 | Selected request pin |
| svc_hit | output | 1 | An in-service pin was found |
| svc_pin | output | 3 | Highest-priority in-service pin |
| low_pin | output | 3 | Current lowest-priority pointer |

## Verification
The output assertions assume that the three vectors and the mode flags are stable, defined values at each sampled clock edge. The bench changes them only on the falling edge. The pointer assertions assume `op` is driven for exactly one cycle per command. The bench's command task returns `op` to 0 before the next rising edge. Random vectors are drawn for every one of the eight pointer values, with both flags varied. Sparse in-service patterns are mixed in so that blocking and non-blocking cases both occur often.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    parameter int unsigned PIN_COUNT = 8;
    localparam int unsigned PIN_W = $clog2(PIN_COUNT);

    typedef logic [PIN_COUNT-1:0] pin_vec_t;
    typedef logic [PIN_W-1:0]     pin_idx_t;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_INIT     = 3'd1,
        OP_EOI_ANY  = 3'd2,
        OP_EOI_PIN  = 3'd3,
        OP_SET_LOW  = 3'd4,
        OP_ACK_AUTO = 3'd5
    } prio_op_e;

    typedef struct packed {
        logic     hit;
        pin_idx_t pin;
    } pick_t;

    // Reorder a pin vector so that slot 0 holds the top-priority pin.
    function automatic pin_vec_t align_to_low(pin_vec_t v, pin_idx_t low);
        pin_vec_t r;
        for (int k = 0; k < int'(PIN_COUNT); k++) begin
            r[k] = v[(int'(low) + 1 + k) % int'(PIN_COUNT)];
        end
        return r;
    endfunction

    // Map a priority slot back to its physical pin number.
    function automatic pin_idx_t slot_to_pin(pin_idx_t low, pin_idx_t slot);
        return pin_idx_t'((int'(low) + 1 + int'(slot)) % int'(PIN_COUNT));
    endfunction

    // Lowest set slot wins.
    function automatic pick_t first_slot(pin_vec_t v);
        pick_t r;
        r = '0;
        for (int k = int'(PIN_COUNT) - 1; k >= 0; k--) begin
            if (v[k]) begin
                r.hit = 1'b1;
                r.pin = pin_idx_t'(k);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rot_req_picker.sv
module rot_req_picker
    import irq_prio_pkg::*;
#(
    parameter int unsigned CASCADE_PIN = 2
) (
    input  pin_vec_t req_v,
    input  pin_vec_t svc_v,
    input  pin_vec_t mask_v,
    input  pin_idx_t low,
    input  logic     smm,
    input  logic     sfn,
    output pick_t    pick
);
    pin_vec_t blockers;
    pin_vec_t elig_slot;
    pin_vec_t blk_slot;
    pin_vec_t seen;
    pin_vec_t cand;
    pick_t    slot_pick;

    always_comb begin
        blockers = svc_v;
        if (sfn) blockers[CASCADE_PIN] = 1'b0;
        if (smm) blockers = '0;
    end

    assign elig_slot = align_to_low(req_v & ~mask_v, low);
    assign blk_slot  = align_to_low(blockers, low);

    // Running OR of blockers: a blocker at a slot also kills that slot.
    genvar k;
    generate
        for (k = 0; k < int'(PIN_COUNT); k++) begin : g_scan
            if (k == 0) begin : g_first
                assign seen[k] = blk_slot[k];
            end else begin : g_rest
                assign seen[k] = seen[k-1] | blk_slot[k];
            end
            assign cand[k] = elig_slot[k] & ~seen[k];
        end
    endgenerate

    assign slot_pick = first_slot(cand);

    always_comb begin
        pick.hit = slot_pick.hit;
        pick.pin = slot_to_pin(low, slot_pick.pin);
    end
endmodule

// File: rtl/rot_svc_picker.sv
module rot_svc_picker
    import irq_prio_pkg::*;
(
    input  pin_vec_t svc_v,
    input  pin_vec_t mask_v,
    input  pin_idx_t low,
    input  logic     smm,
    output pick_t    pick
);
    pin_vec_t usable;
    pick_t    slot_pick;

    assign usable    = smm ? (svc_v & ~mask_v) : svc_v;
    assign slot_pick = first_slot(align_to_low(usable, low));

    always_comb begin
        pick.hit = slot_pick.hit;
        pick.pin = slot_to_pin(low, slot_pick.pin);
    end
endmodule

// File: rtl/low_ptr_reg.sv
module low_ptr_reg
    import irq_prio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic [2:0] op,
    input  pin_idx_t op_pin,
    input  logic     rotate_en,
    input  pick_t    svc_pick,
    output pin_idx_t low
);
    localparam pin_idx_t LOW_INIT = pin_idx_t'(PIN_COUNT - 1);

    pin_idx_t low_nxt;

    always_comb begin
        low_nxt = low;
        unique case (op)
            OP_INIT:     low_nxt = LOW_INIT;
            OP_EOI_ANY:  if (rotate_en && svc_pick.hit) low_nxt = svc_pick.pin;
            OP_EOI_PIN,
            OP_SET_LOW,
            OP_ACK_AUTO: if (rotate_en) low_nxt = op_pin;
            default:     low_nxt = low;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) low <= LOW_INIT;
        else     low <= low_nxt;
    end

    a_r8_init_low: assert property (@(posedge clk) disable iff (rst)
        op == OP_INIT |=> low == LOW_INIT);
    a_r10_pin_eoi_rotates: assert property (@(posedge clk) disable iff (rst)
        (op == OP_EOI_PIN && rotate_en) |=> low == $past(op_pin));
    a_r13_idle_holds: assert property (@(posedge clk) disable iff (rst)
        op == OP_NONE |=> $stable(low));
    a_r11_no_rot_holds: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SET_LOW && !rotate_en) |=> $stable(low));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int unsigned CASCADE_PIN = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_bits,
    input  logic [7:0] svc_bits,
    input  logic [7:0] mask_bits,
    input  logic       smm_en,
    input  logic       sfn_en,
    input  logic [2:0] op,
    input  logic [2:0] op_pin,
    input  logic       rotate_en,
    output logic       req_hit,
    output logic [2:0] req_pin,
    output logic       svc_hit,
    output logic [2:0] svc_pin,
    output logic [2:0] low_pin
);
    pick_t    req_pick;
    pick_t    svc_pick;
    pin_idx_t low;

    rot_req_picker #(.CASCADE_PIN(CASCADE_PIN)) u_req (
        .req_v (req_bits),
        .svc_v (svc_bits),
        .mask_v(mask_bits),
        .low   (low),
        .smm   (smm_en),
        .sfn   (sfn_en),
        .pick  (req_pick)
    );

    rot_svc_picker u_svc (
        .svc_v (svc_bits),
        .mask_v(mask_bits),
        .low   (low),
        .smm   (smm_en),
        .pick  (svc_pick)
    );

    low_ptr_reg u_low (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .op_pin   (op_pin),
        .rotate_en(rotate_en),
        .svc_pick (svc_pick),
        .low      (low)
    );

    assign req_hit = req_pick.hit;
    assign req_pin = req_pick.pin;
    assign svc_hit = svc_pick.hit;
    assign svc_pin = svc_pick.pin;
    assign low_pin = low;

    a_r2_winner_eligible: assert property (@(posedge clk) disable iff (rst)
        req_hit |-> (req_bits[req_pin] && !mask_bits[req_pin]));
    a_r3_winner_not_in_service: assert property (@(posedge clk) disable iff (rst)
        (req_hit && !smm_en && !sfn_en) |-> !svc_bits[req_pin]);
    a_r6_svc_pin_set: assert property (@(posedge clk) disable iff (rst)
        svc_hit |-> svc_bits[svc_pin]);
    a_r6_svc_none: assert property (@(posedge clk) disable iff (rst)
        (svc_bits == 8'h00) |-> !svc_hit);
    a_r7_smm_skips_masked: assert property (@(posedge clk) disable iff (rst)
        (svc_hit && smm_en) |-> !mask_bits[svc_pin]);
    a_r9_eoi_any_rotates: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd2 && rotate_en && svc_hit) |=> low_pin == $past(svc_pin));
endmodule

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/1ps
module irq_prio_resolver_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] req_bits, svc_bits, mask_bits;
    logic       smm_en, sfn_en, rotate_en;
    logic [2:0] op, op_pin;
    logic       req_hit, svc_hit;
    logic [2:0] req_pin, svc_pin, low_pin;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_resolver uut (
        .clk(clk), .rst(rst),
        .req_bits(req_bits), .svc_bits(svc_bits), .mask_bits(mask_bits),
        .smm_en(smm_en), .sfn_en(sfn_en),
        .op(op), .op_pin(op_pin), .rotate_en(rotate_en),
        .req_hit(req_hit), .req_pin(req_pin),
        .svc_hit(svc_hit), .svc_pin(svc_pin), .low_pin(low_pin)
    );

    // Reference scans, written from the requirements. Result: {hit, pin}.
    function automatic logic [3:0] exp_req(logic [7:0] rq, logic [7:0] sv,
                                           logic [7:0] mk, logic [2:0] lo,
                                           logic smm, logic sfn);
        logic [7:0] blk;
        blk = sv;
        if (sfn) blk[2] = 1'b0;
        if (smm) blk = 8'h00;
        for (int k = 0; k < 8; k++) begin
            int p;
            p = (int'(lo) + 1 + k) % 8;
            if (blk[p]) return 4'h0;
            if (rq[p] && !mk[p]) return {1'b1, 3'(p)};
        end
        return 4'h0;
    endfunction

    function automatic logic [3:0] exp_svc(logic [7:0] sv, logic [7:0] mk,
                                           logic [2:0] lo, logic smm);
        for (int k = 0; k < 8; k++) begin
            int p;
            p = (int'(lo) + 1 + k) % 8;
            if (sv[p] && !(smm && mk[p])) return {1'b1, 3'(p)};
        end
        return 4'h0;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Apply vectors at negedge, sample outputs shortly before the next posedge.
    task automatic apply(input logic [7:0] rq, input logic [7:0] sv, input logic [7:0] mk,
                         input logic smm, input logic sfn);
        @(negedge clk);
        req_bits = rq; svc_bits = sv; mask_bits = mk; smm_en = smm; sfn_en = sfn;
        #1;
    endtask

    task automatic check_outputs(input string tag);
        logic [3:0] er, es;
        er = exp_req(req_bits, svc_bits, mask_bits, low_pin, smm_en, sfn_en);
        es = exp_svc(svc_bits, mask_bits, low_pin, smm_en);
        check({tag, " req"}, {4'h0, req_hit, (req_hit ? req_pin : 3'd0)}, {4'h0, er});
        check({tag, " svc"}, {4'h0, svc_hit, (svc_hit ? svc_pin : 3'd0)}, {4'h0, es});
    endtask

    // One-cycle command; pointer read back at the following negedge.
    task automatic command(input logic [2:0] o, input logic [2:0] p, input logic rot);
        @(negedge clk);
        op = o; op_pin = p; rotate_en = rot;
        @(negedge clk);
        op = 3'd0; rotate_en = 1'b0;
        #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req_bits = 0; svc_bits = 0; mask_bits = 0;
        smm_en = 0; sfn_en = 0; op = 0; op_pin = 0; rotate_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8 reset pointer", {5'd0, low_pin}, 8'd7);

        // R1/R2: pin 0 first after reset; masked pin skipped
        apply(8'h81, 8'h00, 8'h00, 0, 0);
        check("R1 pin0 first", {4'h0, req_hit, req_pin}, 8'h08);
        apply(8'h81, 8'h00, 8'h01, 0, 0);
        check("R2 masked skipped", {4'h0, req_hit, req_pin}, 8'h0F);
        // R3: in-service pin 2 blocks pin 3 but not pin 1
        apply(8'h08, 8'h04, 8'h00, 0, 0);
        check("R3 blocked", {7'd0, req_hit}, 8'h00);
        apply(8'h0A, 8'h04, 8'h00, 0, 0);
        check("R3 higher wins", {4'h0, req_hit, req_pin}, 8'h09);
        apply(8'h04, 8'h04, 8'h00, 0, 0);
        check("R3 same pin blocks", {7'd0, req_hit}, 8'h00);
        // R5: cascade in-service bit ignored
        apply(8'h08, 8'h04, 8'h00, 0, 1);
        check("R5 cascade exempt", {4'h0, req_hit, req_pin}, 8'h0B);
        apply(8'h08, 8'h02, 8'h00, 0, 1);
        check("R5 other still blocks", {7'd0, req_hit}, 8'h00);
        // R4: special mask mode ignores in-service
        apply(8'h80, 8'h01, 8'h00, 1, 0);
        check("R4 smm ignores svc", {4'h0, req_hit, req_pin}, 8'h0F);
        // R6/R7
        apply(8'h00, 8'h30, 8'h00, 0, 0);
        check("R6 svc pin", {4'h0, svc_hit, svc_pin}, 8'h0C);
        apply(8'h00, 8'h00, 8'h00, 0, 0);
        check("R6 svc none", {7'd0, svc_hit}, 8'h00);
        apply(8'h00, 8'h30, 8'h10, 1, 0);
        check("R7 smm skips masked", {4'h0, svc_hit, svc_pin}, 8'h0D);
        apply(8'h00, 8'h30, 8'h10, 0, 0);
        check("R7 no smm keeps masked", {4'h0, svc_hit, svc_pin}, 8'h0C);

        // R9 general EOI
        apply(8'h00, 8'h20, 8'h00, 0, 0);
        command(3'd2, 3'd0, 1'b0);
        check("R9 no rotate", {5'd0, low_pin}, 8'd7);
        command(3'd2, 3'd0, 1'b1);
        check("R9 rotate to svc", {5'd0, low_pin}, 8'd5);
        apply(8'h00, 8'h00, 8'h00, 0, 0);
        command(3'd2, 3'd0, 1'b1);
        check("R9 nothing in service", {5'd0, low_pin}, 8'd5);
        // R1 after rotation: pin 6 first
        apply(8'h41, 8'h00, 8'h00, 0, 0);
        check("R1 wrap order", {4'h0, req_hit, req_pin}, 8'h0E);
        // R10
        command(3'd3, 3'd2, 1'b0);
        check("R10 no rotate", {5'd0, low_pin}, 8'd5);
        command(3'd3, 3'd2, 1'b1);
        check("R10 pin eoi", {5'd0, low_pin}, 8'd2);
        // R11
        command(3'd4, 3'd6, 1'b0);
        check("R11 ignored", {5'd0, low_pin}, 8'd2);
        command(3'd4, 3'd6, 1'b1);
        check("R11 set", {5'd0, low_pin}, 8'd6);
        // R12
        command(3'd5, 3'd1, 1'b1);
        check("R12 ack", {5'd0, low_pin}, 8'd1);
        // R13
        command(3'd0, 3'd4, 1'b1);
        check("R13 none", {5'd0, low_pin}, 8'd1);
        command(3'd6, 3'd4, 1'b1);
        check("R13 code6", {5'd0, low_pin}, 8'd1);
        command(3'd7, 3'd4, 1'b1);
        check("R13 code7", {5'd0, low_pin}, 8'd1);
        // R8 init
        command(3'd1, 3'd3, 1'b1);
        check("R8 init", {5'd0, low_pin}, 8'd7);

        // Random sweep over every pointer value (R1..R7)
        for (int lo = 0; lo < 8; lo++) begin
            command(3'd4, 3'(lo), 1'b1);
            check("R11 sweep set", {5'd0, low_pin}, 8'(lo));
            for (int n = 0; n < 60; n++) begin
                logic [7:0] rq, sv, mk;
                rq = 8'($urandom);
                mk = 8'($urandom) & 8'($urandom);
                sv = ($urandom % 3 == 0) ? 8'h00 : (8'($urandom) & 8'($urandom) & 8'($urandom));
                apply(rq, sv, mk, ($urandom % 4 == 0), ($urandom % 2 == 0));
                check_outputs("R1-sweep");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule